// File: doc/BRIEF.md
# Codec Input Frame Serializer

This block builds the codec-to-controller input frame of an AC'97-style serial audio link and shifts it out one bit per bit clock. On the bit clock that sees the frame-sync input go from low to high, it takes a snapshot of its inputs into a 256-bit frame. The snapshot holds the codec-ready flag, the echoed register index and read data with their valid flag, the left and right 20-bit ADC samples, and the slot-request bits. From the next bit on, the frame leaves on the serial output, most significant bit first. A 16-bit tag slot comes first, then twelve 20-bit slots. After the last bit the output stays low until the next sync rise.

The ADC stereo pair can go into one of four slot pairs, chosen by a 2-bit select. The slot-request bits for the chosen pair depend on the variable-rate mode, the ADC power state, whether the rate is 48 kHz, and whether the codec needs a sample in this frame. Samples arrive on a valid/ready interface. `smp_ready_o` is high only in the cycle that detects a sync rise. A sample is taken only when `smp_valid_i` is high in that cycle. A producer whose sample is not taken must hold it and its valid flag until the next ready cycle. A frame that takes no sample tags its ADC slots invalid and fills them with zeros.

Top module: `codec_rx_frame_ser`

## Requirements
- R1: In the tag slot (bits 15:0, sent first), bit 15 is `codec_ready_i`. Bit 15-s marks slot s (1..12) valid. Slots 1 and 2 are marked valid when `stat_valid_i` is high. The two ADC slots are marked valid when a sample was accepted. All other tag bits are 0.
- R2: In slot 1, bits 18:12 carry `stat_index_i` when the status is valid and zeros otherwise. Bits 11:2 are the slot-request bits, with slot n at bit 14-n, so slot 3 is at bit 11 and slot 12 at bit 2. Bits 19, 1 and 0 are 0.
- R3: In slot 2, bits 19:4 carry `stat_data_i` and bits 3:0 are 0. When `stat_valid_i` is low, all 20 bits are 0.
- R4: `pair_sel_i` places the left/right samples as follows: 0 in slots 3/4, 1 in slots 6/9, 2 in slots 7/8, 3 in slots 10/11.
- R5: An accepted sample fills its whole 20-bit slot, MSB first. The ADC slots are zero when no sample was accepted. Slot 5 and every slot that carries no data are always zero.
- R6: All slot-request bits are 0 when `var_rate_i` is low or when `adc_pwr_ok_i` is low.
- R7: The request bits of the two mapped ADC slots are 1 only when variable-rate mode is on, the ADC is power-ready, the rate is not 48 kHz, and `need_sample_i` is low. Request bits of all other slots are always 0.
- R8: The edge that detects a low-to-high change of `sync_i` loads the frame. Tag bit 15 is on `sdata_o` after that edge, and each following rising edge brings the next bit. After 256 bits the output stays 0 until the next sync rise.
- R9: `smp_ready_o` is high only in a cycle where `sync_i` is high, it was low at the previous edge, and reset is released. It is therefore never high two cycles in a row.
- R10: While reset is held, `sdata_o` and `smp_ready_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low reset, synchronous to `bit_clk` |
| sync_i | input | 1 | Frame sync; a rising edge starts a frame |
| codec_ready_i | input | 1 | Codec-ready flag for tag bit 15 |
| stat_valid_i | input | 1 | Register read-back present in this frame |
| stat_index_i | input | 7 | Echoed register index |
| stat_data_i | input | 16 | Register read data |
| smp_valid_i | input | 1 | ADC sample pair valid |
| smp_ready_o | output | 1 | Sample pair accepted in this cycle when valid |
| smp_left_i | input | 20 | Left ADC sample |
| smp_right_i | input | 20 | Right ADC sample |
| var_rate_i | input | 1 | Variable-rate mode enabled |
| adc_pwr_ok_i | input | 1 | ADC powered and ready |
| rate_is_48k_i | input | 1 | ADC rate is 48 kHz |
| need_sample_i | input | 1 | Codec needs a sample in this frame |
| pair_sel_i | input | 2 | ADC slot-pair select |
| sdata_o | output | 1 | Serial frame data, MSB first |

## Verification
A wrong snapshot or wrong slot placement corrupts a whole 20-bit field of the next frame. It shows on `sdata_o` within that frame's 256 bits, at the slot's known bit offset. A bad shift counter or a missed sync detect shifts every later bit by a fixed amount, so the tag slot is already wrong in its first 16 bit times. A wrong request-bit rule shows only in bits 11:2 of slot 1. That is why each rate and power case gets a frame of its own.

// File: rtl/codec_frame_pkg.sv
package codec_frame_pkg;
  localparam int TAG_W    = 16;
  localparam int SLOT_W   = 20;
  localparam int N_SLOTS  = 12;
  localparam int FRAME_W  = TAG_W + N_SLOTS * SLOT_W;
  localparam int IDX_W    = 7;
  localparam int RD_W     = 16;
  localparam int SMP_W    = 20;
  localparam int SLOTN_W  = 4;

  typedef logic [SLOTN_W-1:0] slot_num_t;

  typedef struct packed {
    slot_num_t left;
    slot_num_t right;
  } slot_pair_t;

  // Bit position of the LSB of slot s (1..N_SLOTS) inside the frame vector.
  function automatic int slot_lsb(input int s);
    return FRAME_W - TAG_W - SLOT_W * s;
  endfunction
endpackage

// File: rtl/pair_slot_map.sv
module pair_slot_map
  import codec_frame_pkg::*;
(
  input  logic [1:0] sel_i,
  output slot_pair_t pair_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    pair_o = '{left: slot_num_t'(3),  right: slot_num_t'(4)};
      2'd1:    pair_o = '{left: slot_num_t'(6),  right: slot_num_t'(9)};
      2'd2:    pair_o = '{left: slot_num_t'(7),  right: slot_num_t'(8)};
      default: pair_o = '{left: slot_num_t'(10), right: slot_num_t'(11)};
    endcase
  end
endmodule

// File: rtl/frame_assembler.sv
module frame_assembler
  import codec_frame_pkg::*;
(
  input  logic               codec_ready_i,
  input  logic               stat_valid_i,
  input  logic [IDX_W-1:0]   stat_index_i,
  input  logic [RD_W-1:0]    stat_data_i,
  input  logic               smp_take_i,
  input  logic [SMP_W-1:0]   smp_left_i,
  input  logic [SMP_W-1:0]   smp_right_i,
  input  logic               req_ok_i,
  input  slot_pair_t         pair_i,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int REQ_TOP = 14;  // slot n request sits at slot-1 bit REQ_TOP-n

  logic [SLOT_W-1:0] slot_d [1:N_SLOTS];
  logic [N_SLOTS:1]  slot_v;

  for (genvar s = 1; s <= N_SLOTS; s++) begin : g_slot
    if (s == 1) begin : g_cmd
      always_comb begin
        slot_d[s] = '0;
        if (stat_valid_i) slot_d[s][18:12] = stat_index_i;
        for (int n = 3; n <= N_SLOTS; n++) begin
          slot_d[s][REQ_TOP-n] = req_ok_i &&
              (slot_num_t'(n) == pair_i.left || slot_num_t'(n) == pair_i.right);
        end
        slot_v[s] = stat_valid_i;
      end
    end else if (s == 2) begin : g_stat
      always_comb begin
        slot_d[s] = stat_valid_i ? {stat_data_i, 4'b0000} : '0;
        slot_v[s] = stat_valid_i;
      end
    end else begin : g_pcm
      always_comb begin
        slot_d[s] = '0;
        slot_v[s] = 1'b0;
        if (smp_take_i && slot_num_t'(s) == pair_i.left) begin
          slot_d[s] = smp_left_i;
          slot_v[s] = 1'b1;
        end else if (smp_take_i && slot_num_t'(s) == pair_i.right) begin
          slot_d[s] = smp_right_i;
          slot_v[s] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    frame_o = '0;
    frame_o[FRAME_W-1] = codec_ready_i;
    for (int s = 1; s <= N_SLOTS; s++) begin
      frame_o[FRAME_W-1-s] = slot_v[s];
      frame_o[slot_lsb(s) +: SLOT_W] = slot_d[s];
    end
  end
endmodule

// File: rtl/frame_shift.sv
module frame_shift
  import codec_frame_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sr_q <= '0;
    else if (load_i) sr_q <= frame_i;
    else             sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end

  assign sdata_o = sr_q[FRAME_W-1];
endmodule

// File: rtl/codec_rx_frame_ser.sv
module codec_rx_frame_ser
  import codec_frame_pkg::*;
(
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              codec_ready_i,
  input  logic              stat_valid_i,
  input  logic [IDX_W-1:0]  stat_index_i,
  input  logic [RD_W-1:0]   stat_data_i,
  input  logic              smp_valid_i,
  output logic              smp_ready_o,
  input  logic [SMP_W-1:0]  smp_left_i,
  input  logic [SMP_W-1:0]  smp_right_i,
  input  logic              var_rate_i,
  input  logic              adc_pwr_ok_i,
  input  logic              rate_is_48k_i,
  input  logic              need_sample_i,
  input  logic [1:0]        pair_sel_i,
  output logic              sdata_o
);
  logic               sync_q;
  logic               sync_rise;
  logic               req_ok;
  slot_pair_t         pair;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge bit_clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_i;
  end

  assign sync_rise   = rst_n && sync_i && !sync_q;
  assign smp_ready_o = sync_rise;
  assign req_ok      = var_rate_i && adc_pwr_ok_i && !rate_is_48k_i && !need_sample_i;

  pair_slot_map u_map (
    .sel_i  (pair_sel_i),
    .pair_o (pair)
  );

  frame_assembler u_asm (
    .codec_ready_i (codec_ready_i),
    .stat_valid_i  (stat_valid_i),
    .stat_index_i  (stat_index_i),
    .stat_data_i   (stat_data_i),
    .smp_take_i    (smp_valid_i && sync_rise),
    .smp_left_i    (smp_left_i),
    .smp_right_i   (smp_right_i),
    .req_ok_i      (req_ok),
    .pair_i        (pair),
    .frame_o       (frame)
  );

  frame_shift u_shift (
    .clk     (bit_clk),
    .rst_n   (rst_n),
    .load_i  (sync_rise),
    .frame_i (frame),
    .sdata_o (sdata_o)
  );
endmodule

// File: rtl/codec_rx_frame_chk.sv
module codec_rx_frame_chk
  import codec_frame_pkg::*;
(
  input logic bit_clk,
  input logic rst_n,
  input logic sync_i,
  input logic smp_ready_o,
  input logic codec_ready_i,
  input logic var_rate_i,
  input logic adc_pwr_ok_i,
  input logic sdata_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int S5_LO = TAG_W + 4 * SLOT_W;
  localparam int S2_LO = TAG_W + 2 * SLOT_W - 4;
  localparam int RQ_LO = TAG_W + 8;
  localparam int RQ_HI = TAG_W + 17;

  logic [CNT_W-1:0] pos_q;
  logic             req_gate_q;

  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      pos_q      <= CNT_W'(FRAME_W);
      req_gate_q <= 1'b0;
    end else if (smp_ready_o) begin
      pos_q      <= '0;
      req_gate_q <= var_rate_i && adc_pwr_ok_i;
    end else if (pos_q != CNT_W'(FRAME_W)) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assert_ready_single_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    smp_ready_o |=> !smp_ready_o);
  assert_ready_needs_sync_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    smp_ready_o |-> sync_i);
  assert_first_bit_R1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    smp_ready_o |=> (sdata_o == $past(codec_ready_i)));
  assert_idle_low_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (pos_q == CNT_W'(FRAME_W)) |-> !sdata_o);
  assert_slot5_zero_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (pos_q >= CNT_W'(S5_LO) && pos_q < CNT_W'(S5_LO + SLOT_W)) |-> !sdata_o);
  assert_stat_pad_zero_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (pos_q >= CNT_W'(S2_LO) && pos_q < CNT_W'(S2_LO + 4)) |-> !sdata_o);
  assert_req_gated_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!req_gate_q && pos_q >= CNT_W'(RQ_LO) && pos_q <= CNT_W'(RQ_HI)) |-> !sdata_o);
endmodule

bind codec_rx_frame_ser codec_rx_frame_chk u_chk (
  .bit_clk       (bit_clk),
  .rst_n         (rst_n),
  .sync_i        (sync_i),
  .smp_ready_o   (smp_ready_o),
  .codec_ready_i (codec_ready_i),
  .var_rate_i    (var_rate_i),
  .adc_pwr_ok_i  (adc_pwr_ok_i),
  .sdata_o       (sdata_o)
);

// File: tb/tb_codec_rx_frame_ser.sv
module tb_codec_rx_frame_ser;
  logic        bit_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0;
  logic        codec_ready_i = 1'b0;
  logic        stat_valid_i = 1'b0;
  logic [6:0]  stat_index_i = '0;
  logic [15:0] stat_data_i = '0;
  logic        smp_valid_i = 1'b0;
  logic        smp_ready_o;
  logic [19:0] smp_left_i = '0;
  logic [19:0] smp_right_i = '0;
  logic        var_rate_i = 1'b0;
  logic        adc_pwr_ok_i = 1'b0;
  logic        rate_is_48k_i = 1'b0;
  logic        need_sample_i = 1'b0;
  logic [1:0]  pair_sel_i = '0;
  logic        sdata_o;

  int checks = 0;
  int errors = 0;
  logic [255:0] exp_q[$];
  bit mon_busy = 1'b0;

  always #4 bit_clk = ~bit_clk;

  codec_rx_frame_ser dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [19:0] slot_of(input logic [255:0] f, input int s);
    return 20'(f >> (220 - 20 * (s - 1)));
  endfunction

  // Reference frame computed from the requirements.
  function automatic logic [255:0] model(input bit take);
    logic [255:0] f = '0;
    int l, r;
    bit rq;
    logic [19:0] s1 = '0;
    case (pair_sel_i)
      2'd0: begin l = 3;  r = 4;  end
      2'd1: begin l = 6;  r = 9;  end
      2'd2: begin l = 7;  r = 8;  end
      default: begin l = 10; r = 11; end
    endcase
    rq = var_rate_i && adc_pwr_ok_i && !rate_is_48k_i && !need_sample_i;
    f[255] = codec_ready_i;
    f[254] = stat_valid_i;
    f[253] = stat_valid_i;
    if (take) begin f[255 - l] = 1'b1; f[255 - r] = 1'b1; end
    if (stat_valid_i) s1[18:12] = stat_index_i;
    if (rq) begin s1[14 - l] = 1'b1; s1[14 - r] = 1'b1; end
    f[220 +: 20] = s1;
    if (stat_valid_i) f[200 +: 20] = {stat_data_i, 4'b0};
    if (take) begin
      f[(220 - 20 * (l - 1)) +: 20] = smp_left_i;
      f[(220 - 20 * (r - 1)) +: 20] = smp_right_i;
    end
    return f;
  endfunction

  // Monitor: collects each frame bit by bit and compares per slot.
  initial begin
    logic [255:0] exp, got;
    string req;
    forever begin
      wait (exp_q.size() > 0);
      mon_busy = 1'b1;
      exp = exp_q.pop_front();
      for (int i = 0; i < 256; i++) begin
        @(negedge bit_clk);
        got[255 - i] = sdata_o;
      end
      @(negedge bit_clk);
      check(sdata_o == 1'b0, "R8", "idle after frame", 32'(sdata_o), 0);
      check(got[255:240] == exp[255:240], "R1", "tag slot",
            32'(got[255:240]), 32'(exp[255:240]));
      for (int s = 1; s <= 12; s++) begin
        if (s == 1) req = "R2 R6 R7 slot1";
        else if (s == 2) req = "R3 slot2";
        else if (s == 5) req = "R5 slot5";
        else req = "R4 R5 pcm slot";
        check(slot_of(got, s) == slot_of(exp, s), req, $sformatf("slot %0d", s),
              32'(slot_of(got, s)), 32'(slot_of(exp, s)));
      end
      mon_busy = 1'b0;
    end
  end

  // Driver: raises sync, checks the handshake, pushes the expected frame.
  task automatic send_frame(input bit offer);
    @(negedge bit_clk);
    smp_valid_i = offer;
    sync_i = 1'b1;
    #1;
    check(smp_ready_o == 1'b1, "R9", "ready on sync rise", 32'(smp_ready_o), 1);
    exp_q.push_back(model(offer));
    @(negedge bit_clk);
    check(smp_ready_o == 1'b0, "R9", "ready one cycle only", 32'(smp_ready_o), 0);
    smp_valid_i = 1'b0;
    repeat (15) @(negedge bit_clk);
    sync_i = 1'b0;
    wait (exp_q.size() == 0 && !mon_busy);
    repeat (3) @(negedge bit_clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sync_i = 1'b1;
    repeat (3) @(negedge bit_clk);
    check(sdata_o == 1'b0, "R10", "sdata in reset", 32'(sdata_o), 0);
    check(smp_ready_o == 1'b0, "R10", "ready in reset", 32'(smp_ready_o), 0);
    sync_i = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge bit_clk);

    // Fixed rate, pair 3/4, status valid.
    codec_ready_i = 1; stat_valid_i = 1; stat_index_i = 7'h26; stat_data_i = 16'hA5C3;
    smp_left_i = 20'hF0123; smp_right_i = 20'h8ABCD; pair_sel_i = 0;
    var_rate_i = 0; adc_pwr_ok_i = 1;
    send_frame(1);
    // Variable rate, all conditions met, pair 6/9.
    pair_sel_i = 1; var_rate_i = 1; smp_left_i = 20'h13579; smp_right_i = 20'hFFFFF;
    send_frame(1);
    // 48 kHz, status invalid, pair 7/8.
    pair_sel_i = 2; rate_is_48k_i = 1; stat_valid_i = 0; smp_left_i = 20'h80001;
    send_frame(1);
    // Powered down, no sample offered, pair 10/11.
    pair_sel_i = 3; rate_is_48k_i = 0; adc_pwr_ok_i = 0;
    send_frame(0);
    // Sample needed, codec not ready, pair 10/11 with sample.
    adc_pwr_ok_i = 1; need_sample_i = 1; codec_ready_i = 0; stat_valid_i = 1;
    stat_index_i = 7'h7F; stat_data_i = 16'hFFFF;
    send_frame(1);
    // Requests on, pair 3/4.
    need_sample_i = 0; codec_ready_i = 1; pair_sel_i = 0; smp_left_i = 20'h00001;
    send_frame(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule